// File: doc/BRIEF.md
# Low-Power Clock Source Sequencer

This block sits in the clock controller of a microcontroller. It controls two high-speed clock sources, a PLL and an external high-frequency oscillator, and the select line of the main-clock mux. The other mux input is always the internal system oscillator. Software sets the enable bits for the sources and chooses whether the main clock runs from a high-speed source, and which one. The block follows those settings in run mode. Whenever a source is enabled and reports ready, it steers the main clock to the chosen source.

When a stop or standby request arrives, the block waits until every enabled source has finished starting up. It then records which sources were on and which main-clock source was in use. Next it moves the main clock to the internal oscillator and turns both sources off. Once both ready flags have dropped, it reports the low-power mode.

A wake event starts the exit sequence:
- The processor keeps running from the internal oscillator.
- The sources that were on before entry are restarted.
- The main clock returns to the recorded high-speed source as soon as that source is ready.
- At that point a sticky "high-speed clock good" flag is set, which can raise a maskable interrupt.

If software clears an enable bit during this window, the restore for that source is cancelled and the main clock stays on the oscillator. All pins are plain level-style control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `lp_clk_seq`

## Requirements
- R1: From the clock edge that accepts a low-power request, `pll_en` and `hfx_en` are low. `in_stop`/`in_stby` rise only after both `pll_rdy` and `hfx_rdy` are low, and while either one is high the enables stay low.
- R2: A request (`stop_req` or `stby_req`, level) is held unaccepted while any source whose enable bit is set has its ready flag low. It is accepted in the first run-mode cycle in which no enabled source is starting. If both requests are high, standby is taken (`in_stby`=1, `in_stop`=0).
- R3: `mclk_sel` encodes 0 = internal oscillator, 1 = external oscillator, 2 = PLL. It becomes 0 at the accepting edge and stays 0 through entry, low-power and the wake window until a restore.
- R4: The cycle after `wake` is sampled in low-power mode, each source enable is high only if it was high at acceptance and its software enable bit is still set.
- R5: After wake, `mclk_sel` changes to the recorded high-speed source at the edge following the first cycle in which that source is enabled and ready. `mclk_sel` never names a source whose ready flag is low.
- R6: The restore switch sets `hs_good_flag`. The flag stays set until `irq_clr` is high for one cycle, and a set in the same cycle takes priority over the clear. `hs_good_irq` equals `hs_good_flag` AND `irq_en`.
- R7: If software clears the enable bit of the recorded source during the wake window, the restore is cancelled: that enable drops, `mclk_sel` stays 0 and `hs_good_flag` is not set.
- R8: In run mode, `mclk_sel` follows the software choice one edge after the chosen source is enabled and ready, and is 0 while it is not. Such switches never set `hs_good_flag`.
- R9: If the main clock was on the internal oscillator at acceptance, wake returns straight to run mode without setting `hs_good_flag`, and a new low-power request is accepted again.
- R10: After reset all outputs are low and the block is in run mode with the oscillator selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | Level request to enter stop mode |
| stby_req | input | 1 | Level request to enter standby mode |
| wake | input | 1 | Wake event, sampled while in low-power mode |
| pll_sw_en | input | 1 | Software enable bit for the PLL |
| hfx_sw_en | input | 1 | Software enable bit for the external oscillator |
| mclk_hs_sw | input | 1 | Software wants the main clock from a high-speed source |
| hs_src_pll_sw | input | 1 | High-speed source choice: 1 PLL, 0 external oscillator |
| pll_rdy | input | 1 | PLL started and usable |
| hfx_rdy | input | 1 | External oscillator started and usable |
| irq_en | input | 1 | Interrupt mask bit for the clock-good flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the clock-good flag |
| pll_en | output | 1 | PLL enable |
| hfx_en | output | 1 | External oscillator enable |
| mclk_sel | output | 2 | Main-clock mux select (0 osc, 1 ext, 2 PLL) |
| in_stop | output | 1 | Block is in stop mode |
| in_stby | output | 1 | Block is in standby mode |
| hs_good_flag | output | 1 | Sticky high-speed clock good status |
| hs_good_irq | output | 1 | Masked clock-good interrupt |

## Verification
The bound assertions check the following on every cycle:
- Low-power mode always shows both sources off and not ready, with the oscillator selected.
- The two mode indicators are never high together.
- The mux select never names a source that is not ready.
- The interrupt output follows the flag and the mask.
- The flag holds until it is cleared.

Some behaviours depend on history, and only the bench scenarios can show them:
- Which sources come back after wake, which depends on what was on at entry.
- Requests held back while a source is still starting.
- Standby priority.
- Cancelling a restore during the wake window.
- A wake that needs no restore.

The bench's reference model follows these sequences cycle by cycle.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;
  localparam int MSEL_W = 2;
  localparam int NSRC   = 2;
  localparam int IDX_PLL = 0;
  localparam int IDX_HFX = 1;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_LP    = 2'd2,
    ST_WAKE  = 2'd3
  } seq_state_t;

  typedef enum logic [MSEL_W-1:0] {
    SEL_OSC = 2'd0,
    SEL_HFX = 2'd1,
    SEL_PLL = 2'd2
  } msel_t;
endpackage

// File: rtl/lpcs_gate.sv
module lpcs_gate #(
  parameter int N = 2
) (
  input  logic         in_run,
  input  logic         stop_req,
  input  logic         stby_req,
  input  logic [N-1:0] want,
  input  logic [N-1:0] rdy,
  output logic         accept,
  output logic         pick_stby
);
  logic [N-1:0] starting;

  for (genvar i = 0; i < N; i++) begin : g_busy
    assign starting[i] = want[i] & ~rdy[i];
  end

  assign accept    = in_run & (stop_req | stby_req) & ~(|starting);
  assign pick_stby = stby_req;
endmodule

// File: rtl/lpcs_ctx.sv
module lpcs_ctx #(
  parameter int N     = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [N-1:0]     en_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             stby_in,
  output logic [N-1:0]     en_saved,
  output logic [SEL_W-1:0] sel_saved,
  output logic             stby_saved
);
  for (genvar i = 0; i < N; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_saved[i] <= 1'b0;
      else if (capture) en_saved[i] <= en_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_saved  <= '0;
      stby_saved <= 1'b0;
    end else if (capture) begin
      sel_saved  <= sel_in;
      stby_saved <= stby_in;
    end
  end
endmodule

// File: rtl/lpcs_mclk.sv
module lpcs_mclk
  import lpcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  msel_t target,
  input  logic  target_ok,
  output msel_t sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sel <= SEL_OSC;
    else if (load && target_ok) sel <= target;
    else                        sel <= SEL_OSC;
  end
endmodule

// File: rtl/lpcs_irq.sv
module lpcs_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & mask_en;
endmodule

// File: rtl/lp_clk_seq.sv
module lp_clk_seq
  import lpcs_pkg::*;
#(
  parameter int SEL_W = MSEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             stby_req,
  input  logic             wake,
  input  logic             pll_sw_en,
  input  logic             hfx_sw_en,
  input  logic             mclk_hs_sw,
  input  logic             hs_src_pll_sw,
  input  logic             pll_rdy,
  input  logic             hfx_rdy,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             pll_en,
  output logic             hfx_en,
  output logic [SEL_W-1:0] mclk_sel,
  output logic             in_stop,
  output logic             in_stby,
  output logic             hs_good_flag,
  output logic             hs_good_irq
);
  seq_state_t st_q, st_d;
  logic in_run, in_wake;
  logic accept, pick_stby;
  logic [NSRC-1:0] sw_en, rdy_vec, en_saved;
  logic [SEL_W-1:0] sel_saved;
  logic stby_saved;
  msel_t sel_q, sw_target, restore_tgt, mc_target;
  logic restore_alive, restore_ok, restore_now, wake_done;
  logic mc_load, mc_ok;

  function automatic logic src_ready(msel_t s, logic pe, logic he, logic pr, logic hr);
    case (s)
      SEL_PLL: return pe & pr;
      SEL_HFX: return he & hr;
      default: return 1'b1;
    endcase
  endfunction

  assign in_run  = (st_q == ST_RUN);
  assign in_wake = (st_q == ST_WAKE);

  assign sw_en[IDX_PLL]   = pll_sw_en;
  assign sw_en[IDX_HFX]   = hfx_sw_en;
  assign rdy_vec[IDX_PLL] = pll_rdy;
  assign rdy_vec[IDX_HFX] = hfx_rdy;

  // Source enables: follow software in run, restore-gated while waking, off otherwise
  assign pll_en = in_run ? pll_sw_en : (in_wake & en_saved[IDX_PLL] & pll_sw_en);
  assign hfx_en = in_run ? hfx_sw_en : (in_wake & en_saved[IDX_HFX] & hfx_sw_en);

  lpcs_gate #(.N(NSRC)) u_gate (
    .in_run   (in_run),
    .stop_req (stop_req),
    .stby_req (stby_req),
    .want     (sw_en),
    .rdy      (rdy_vec),
    .accept   (accept),
    .pick_stby(pick_stby)
  );

  lpcs_ctx #(.N(NSRC), .SEL_W(SEL_W)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (accept),
    .en_in     (sw_en),
    .sel_in    (sel_q),
    .stby_in   (pick_stby),
    .en_saved  (en_saved),
    .sel_saved (sel_saved),
    .stby_saved(stby_saved)
  );

  always_comb begin
    if (!mclk_hs_sw)        sw_target = SEL_OSC;
    else if (hs_src_pll_sw) sw_target = SEL_PLL;
    else                    sw_target = SEL_HFX;
  end

  assign restore_tgt   = msel_t'(sel_saved);
  assign restore_alive = ((restore_tgt == SEL_PLL) & pll_en) | ((restore_tgt == SEL_HFX) & hfx_en);
  assign restore_ok    = src_ready(restore_tgt, pll_en, hfx_en, pll_rdy, hfx_rdy);
  assign restore_now   = in_wake & restore_alive & restore_ok;
  assign wake_done     = in_wake & (~restore_alive | restore_now);

  assign mc_load   = (in_run & ~accept) | restore_now;
  assign mc_target = in_run ? sw_target : restore_tgt;
  assign mc_ok     = src_ready(mc_target, pll_en, hfx_en, pll_rdy, hfx_rdy);

  lpcs_mclk u_mclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (mc_load),
    .target   (mc_target),
    .target_ok(mc_ok),
    .sel      (sel_q)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:   if (accept) st_d = ST_ENTER;
      ST_ENTER: if (!pll_rdy && !hfx_rdy) st_d = ST_LP;
      ST_LP:    if (wake) st_d = ST_WAKE;
      ST_WAKE:  if (wake_done) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  lpcs_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (restore_now),
    .clr    (irq_clr),
    .mask_en(irq_en),
    .flag   (hs_good_flag),
    .irq    (hs_good_irq)
  );

  assign mclk_sel = sel_q;
  assign in_stop  = (st_q == ST_LP) & ~stby_saved;
  assign in_stby  = (st_q == ST_LP) & stby_saved;
endmodule

// File: rtl/lpcs_chk.sv
module lpcs_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_en,
  input logic             hfx_en,
  input logic             pll_rdy,
  input logic             hfx_rdy,
  input logic [SEL_W-1:0] mclk_sel,
  input logic             in_stop,
  input logic             in_stby,
  input logic             hs_good_flag,
  input logic             hs_good_irq,
  input logic             irq_en,
  input logic             irq_clr
);
  p_lp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop || in_stby) |-> (!pll_en && !hfx_en && !pll_rdy && !hfx_rdy));

  p_mode_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_stop && in_stby));

  p_osc_in_lp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop || in_stby) |-> (mclk_sel == 2'd0));

  p_pll_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_sel == 2'd2) |-> pll_rdy);

  p_hfx_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_sel == 2'd1) |-> hfx_rdy);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_good_irq |-> (hs_good_flag && irq_en));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_good_flag && !irq_clr) |=> hs_good_flag);
endmodule

bind lp_clk_seq lpcs_chk #(.SEL_W(SEL_W)) u_lpcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pll_en      (pll_en),
  .hfx_en      (hfx_en),
  .pll_rdy     (pll_rdy),
  .hfx_rdy     (hfx_rdy),
  .mclk_sel    (mclk_sel),
  .in_stop     (in_stop),
  .in_stby     (in_stby),
  .hs_good_flag(hs_good_flag),
  .hs_good_irq (hs_good_irq),
  .irq_en      (irq_en),
  .irq_clr     (irq_clr)
);

// File: tb/tb_lp_clk_seq.sv
`timescale 1ns/1ps
module tb_lp_clk_seq;
  localparam int PLL_START = 10;
  localparam int HFX_START = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, stby_req = 0, wake = 0;
  logic pll_sw_en = 0, hfx_sw_en = 0, mclk_hs_sw = 0, hs_src_pll_sw = 0;
  logic pll_rdy, hfx_rdy;
  logic irq_en = 0, irq_clr = 0;
  logic pll_en, hfx_en, in_stop, in_stby, hs_good_flag, hs_good_irq;
  logic [1:0] mclk_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lp_clk_seq dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stby_req(stby_req), .wake(wake),
    .pll_sw_en(pll_sw_en), .hfx_sw_en(hfx_sw_en), .mclk_hs_sw(mclk_hs_sw),
    .hs_src_pll_sw(hs_src_pll_sw), .pll_rdy(pll_rdy), .hfx_rdy(hfx_rdy),
    .irq_en(irq_en), .irq_clr(irq_clr), .pll_en(pll_en), .hfx_en(hfx_en),
    .mclk_sel(mclk_sel), .in_stop(in_stop), .in_stby(in_stby),
    .hs_good_flag(hs_good_flag), .hs_good_irq(hs_good_irq)
  );

  // Behavioural source models: ready a fixed count after enable, drops one cycle after disable
  int pll_cnt, hfx_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_cnt <= 0; hfx_cnt <= 0; pll_rdy <= 1'b0; hfx_rdy <= 1'b0;
    end else begin
      if (!pll_en) begin pll_cnt <= 0; pll_rdy <= 1'b0; end
      else begin
        if (pll_cnt < PLL_START) pll_cnt <= pll_cnt + 1;
        pll_rdy <= (pll_cnt >= PLL_START - 1);
      end
      if (!hfx_en) begin hfx_cnt <= 0; hfx_rdy <= 1'b0; end
      else begin
        if (hfx_cnt < HFX_START) hfx_cnt <= hfx_cnt + 1;
        hfx_rdy <= (hfx_cnt >= HFX_START - 1);
      end
    end
  end

  // Reference model: phase 0 run, 1 entering, 2 low power, 3 waking
  int m_ph, m_sel, m_ssel, m_tgt;
  bit m_spll, m_shfx, m_sstby, m_flag, m_set, m_alive, m_ok;

  function automatic bit m_ready(int s, bit pe, bit he);
    if (s == 2) return pe && pll_rdy;
    if (s == 1) return he && hfx_rdy;
    return 1'b1;
  endfunction

  function automatic bit m_pll_en();
    if (m_ph == 0) return pll_sw_en;
    if (m_ph == 3) return m_spll && pll_sw_en;
    return 1'b0;
  endfunction

  function automatic bit m_hfx_en();
    if (m_ph == 0) return hfx_sw_en;
    if (m_ph == 3) return m_shfx && hfx_sw_en;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_sel = 0; m_ssel = 0; m_spll = 0; m_shfx = 0; m_sstby = 0; m_flag = 0;
    end else begin
      m_set = 0;
      case (m_ph)
        0: begin
          if ((stop_req || stby_req) && !(pll_sw_en && !pll_rdy) && !(hfx_sw_en && !hfx_rdy)) begin
            m_spll = pll_sw_en; m_shfx = hfx_sw_en; m_ssel = m_sel; m_sstby = stby_req;
            m_sel = 0; m_ph = 1;
          end else begin
            m_tgt = !mclk_hs_sw ? 0 : (hs_src_pll_sw ? 2 : 1);
            m_sel = m_ready(m_tgt, pll_sw_en, hfx_sw_en) ? m_tgt : 0;
          end
        end
        1: begin
          m_sel = 0;
          if (!pll_rdy && !hfx_rdy) m_ph = 2;
        end
        2: if (wake) m_ph = 3;
        default: begin
          m_alive = (m_ssel == 2) ? (m_spll && pll_sw_en) :
                    (m_ssel == 1) ? (m_shfx && hfx_sw_en) : 1'b0;
          m_ok = m_ready(m_ssel, m_spll && pll_sw_en, m_shfx && hfx_sw_en);
          if (!m_alive) m_ph = 0;
          else if (m_ok) begin m_sel = m_ssel; m_set = 1; m_ph = 0; end
        end
      endcase
      if (m_set) m_flag = 1;
      else if (irq_clr) m_flag = 0;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R1/R4 pll_en", pll_en, m_pll_en());
      check("R1/R4 hfx_en", hfx_en, m_hfx_en());
      check("R3/R5 mclk_sel", mclk_sel, m_sel);
      check("R2 in_stop", in_stop, (m_ph == 2) && !m_sstby);
      check("R2 in_stby", in_stby, (m_ph == 2) && m_sstby);
      check("R6 flag", hs_good_flag, m_flag);
      check("R6 irq", hs_good_irq, m_flag && irq_en);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    int t;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10: reset state
    check("R10 pll_en", pll_en, 0);
    check("R10 hfx_en", hfx_en, 0);
    check("R10 mclk_sel", mclk_sel, 0);
    check("R10 lp", in_stop | in_stby, 0);
    check("R10 flag", hs_good_flag | hs_good_irq, 0);

    // R8: run-mode switch to PLL after it is ready, no interrupt
    pll_sw_en = 1; hfx_sw_en = 1; mclk_hs_sw = 1; hs_src_pll_sw = 1;
    step(2);
    check("R8 not ready keeps osc", mclk_sel, 0);
    for (int i = 0; i < 50 && mclk_sel != 2; i++) step(1);
    check("R8 mclk pll", mclk_sel, 2);
    check("R8 no flag", hs_good_flag, 0);

    // R2: request held while external oscillator restarts
    hfx_sw_en = 0;
    step(2);
    hfx_sw_en = 1; stop_req = 1;
    step(3);
    check("R2 held while starting", in_stop, 0);
    t = 3;
    for (int i = 0; i < 50 && !in_stop; i++) begin step(1); t++; end
    check("R2 stop entered", in_stop, 1);
    check("R2 waited startup", (t > HFX_START) ? 1 : 0, 1);
    check("R1 pll off in lp", pll_en, 0);
    check("R1 hfx off in lp", hfx_en, 0);
    check("R3 osc in lp", mclk_sel, 0);
    stop_req = 0;
    step(2);

    // R4/R5/R6: wake, restore, interrupt
    irq_en = 1; wake = 1;
    step(1);
    wake = 0;
    check("R4 pll back", pll_en, 1);
    check("R4 hfx back", hfx_en, 1);
    check("R3 osc after wake", mclk_sel, 0);
    for (int i = 0; i < 50 && mclk_sel != 2; i++) step(1);
    check("R5 restored pll", mclk_sel, 2);
    check("R6 flag set", hs_good_flag, 1);
    check("R6 irq set", hs_good_irq, 1);
    step(3);
    check("R6 flag sticky", hs_good_flag, 1);
    irq_clr = 1;
    step(1);
    irq_clr = 0;
    check("R6 flag cleared", hs_good_flag, 0);
    check("R6 irq cleared", hs_good_irq, 0);

    // R2: standby priority; R4 only PLL restarts; R7 cancel
    hfx_sw_en = 0;
    step(2);
    stop_req = 1; stby_req = 1;
    for (int i = 0; i < 50 && !(in_stop || in_stby); i++) step(1);
    check("R2 standby wins", in_stby, 1);
    check("R2 stop low", in_stop, 0);
    stop_req = 0; stby_req = 0;
    step(1);
    wake = 1;
    step(1);
    wake = 0;
    check("R4 pll restarted", pll_en, 1);
    check("R4 hfx stays off", hfx_en, 0);
    pll_sw_en = 0;
    step(PLL_START + 5);
    check("R7 pll cancelled", pll_en, 0);
    check("R7 mclk osc", mclk_sel, 0);
    check("R7 no flag", hs_good_flag, 0);

    // R8: chosen source disabled keeps oscillator; R9: osc-only cycle
    check("R8 unready source not selected", mclk_sel, 0);
    mclk_hs_sw = 0;
    stop_req = 1;
    for (int i = 0; i < 50 && !in_stop; i++) step(1);
    stop_req = 0;
    wake = 1;
    step(1);
    wake = 0;
    step(3);
    check("R9 no flag", hs_good_flag, 0);
    check("R9 mclk osc", mclk_sel, 0);
    stop_req = 1;
    for (int i = 0; i < 20 && !in_stop; i++) step(1);
    check("R9 re-entry", in_stop, 1);
    stop_req = 0;
    wake = 1;
    step(1);
    wake = 0;
    step(2);

    // R6 masked: external oscillator path with interrupt masked
    irq_en = 0; hfx_sw_en = 1; mclk_hs_sw = 1; hs_src_pll_sw = 0;
    for (int i = 0; i < 50 && mclk_sel != 1; i++) step(1);
    check("R8 mclk hfx", mclk_sel, 1);
    stby_req = 1;
    for (int i = 0; i < 50 && !in_stby; i++) step(1);
    check("R2 standby alone", in_stby, 1);
    stby_req = 0;
    wake = 1;
    step(1);
    wake = 0;
    for (int i = 0; i < 50 && mclk_sel != 1; i++) step(1);
    check("R5 restored hfx", mclk_sel, 1);
    check("R6 flag masked set", hs_good_flag, 1);
    check("R6 irq masked", hs_good_irq, 0);
    step(2);
    summary();
  end
endmodule